// File: doc/BRIEF.md
# Flash Program-Erase Status Reporter

This block stands in for the status side of a parallel NOR flash while an internal program or erase runs. A one-cycle start pulse latches the operation kind, the target address and the write data. The block then waits for internal pulses. On each pulse it either completes the operation or adds one to a pulse counter. Completion needs the analog side to report the cells settled. A program must also be able to reach its data by clearing bits only. If the counter runs past its limit, the operation is marked as failed and the failure stays latched.

While the block is busy or failed, a read returns a status word instead of array contents. Bit 7 is data polling, bit 6 is toggle, bit 5 is exceeded-limit and bit 3 is erase-timer. Every other bit of the status word reads 0. Once an operation completes, reads return the stored data again. After a failure, only a reset command brings back array reads. A small register array stands in for the cells so that the effect of a program or an erase can be read back.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the block is idle, every array word reads all ones, and a read returns the addressed word on `rd_data` one clock after `rd_en`.
- R2: A program that completes stores the bitwise AND of the old word and the write data. After completion, reads return array data and bit 6 no longer changes between reads.
- R3: In the status word of a program, bit 7 is the complement of bit 7 of the write data when `rd_addr` equals the latched address. It reads 0 at any other address.
- R4: In the status word of an erase, bit 7 reads 0 and bit 3 reads 1. Bit 3 reads 0 during a program. Bits 4, 2, 1 and 0 always read 0.
- R5: Bit 6 reads 0 on the first status read after a start and inverts on every later status read, including while failed.
- R6: Bit 5 reads 0 while an operation is still running.
- R7: A pulse with `cell_busy` high does not complete the operation. Up to PULSE_LIMIT such pulses leave it running, and a completing pulse after them still succeeds. The next non-completing pulse after that sets the failure.
- R8: A program whose data has a 1 where the stored word has a 0 never completes. It fails after PULSE_LIMIT+1 pulses and leaves the word unchanged.
- R9: A failure is latched. Status reads continue with bit 5 = 1 until `rst_cmd` is pulsed, which restores array reads.
- R10: `start` is ignored while busy or failed. `rst_cmd` is ignored while an operation is running.
- R11: An erase that completes sets every array word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start of an operation |
| op_erase | input | 1 | 1 = erase, 0 = program (sampled with start) |
| addr | input | AW | Program target, latched at start |
| wdata | input | DW | Program data, latched at start |
| pulse_tick | input | 1 | Internal pulse strobe |
| cell_busy | input | 1 | High while the cells have not yet settled |
| rst_cmd | input | 1 | Reset command that clears a failure |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address, also qualifies data polling |
| rd_data | output | DW | Array word or status word, registered |

## Verification
On every cycle, the assertions check these behaviours:
- busy and failed are never both set;
- a failure only begins on a pulse that finds the counter at its limit;
- a failure holds until a reset command arrives;
- bit 5 tracks the failure on status reads;
- erase status carries bit 3 and a zero bit 7;
- the toggle inverts on each status read.

Only the bench scenarios can show the data effects:
- the AND-only update on program;
- the whole-array fill on erase;
- the polling value that depends on the address;
- the exact pulse on which the limit boundary is crossed;
- that ignored starts and reset commands leave the array untouched.

// File: rtl/flash_status_unit.sv
module flash_status_unit #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int PULSE_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pulse_tick,
  input  logic          cell_busy,
  input  logic          rst_cmd,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(PULSE_LIMIT + 1) + 1;
  localparam logic [CW-1:0] LIM = CW'(PULSE_LIMIT);

  logic [DW-1:0] mem [DEPTH];
  logic          busy, failed, op_er, tgl;
  logic [AW-1:0] a_lat;
  logic [DW-1:0] d_lat;
  logic [CW-1:0] cnt;

  wire status_mode = busy | failed;
  wire feasible    = op_er | ((d_lat & ~mem[a_lat]) == '0);
  wire done        = busy & pulse_tick & ~cell_busy & feasible;
  wire poll_bit    = ~op_er & (rd_addr == a_lat) & ~d_lat[DW-1];

  logic [DW-1:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[7] = poll_bit;
    stat_word[6] = tgl;
    stat_word[5] = failed;
    stat_word[3] = op_er;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; failed <= 1'b0; op_er <= 1'b0; tgl <= 1'b0;
      a_lat <= '0; d_lat <= '0; cnt <= '0; rd_data <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (start && !status_mode) begin
        busy <= 1'b1; op_er <= op_erase; a_lat <= addr; d_lat <= wdata;
        cnt <= '0; tgl <= 1'b0;
      end else if (busy && pulse_tick) begin
        if (done) begin
          busy <= 1'b0;
          if (op_er) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
          else mem[a_lat] <= mem[a_lat] & d_lat;
        end else if (cnt == LIM) begin
          busy <= 1'b0; failed <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (failed && rst_cmd) failed <= 1'b0;
      if (rd_en) begin
        if (status_mode) begin
          rd_data <= stat_word;
          tgl <= ~tgl;
        end else begin
          rd_data <= mem[rd_addr];
        end
      end
    end
  end

  assert_busy_fail_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && failed));
  assert_fail_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed) |-> ($past(cnt) == LIM && $past(pulse_tick) && $past(busy)));
  assert_fail_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !rst_cmd) |=> failed);
  assert_bit5_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> !rd_data[5]);
  assert_bit5_failed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && failed) |=> rd_data[5]);
  assert_erase_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op_er) |=> (rd_data[3] && !rd_data[7]));
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && status_mode && !start) |=> (tgl != $past(tgl)));
endmodule

// File: tb/flash_status_unit_tb.sv
module flash_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 8;

  logic       clk = 0, rst_n = 0;
  logic       start = 0, op_erase = 0, pulse_tick = 0, cell_busy = 0, rst_cmd = 0, rd_en = 0;
  logic [3:0] addr = 0, rd_addr = 0;
  logic [7:0] wdata = 0, rd_data;
  int checks = 0, failures = 0;
  logic exp_tgl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_unit #(.DW(8), .AW(4), .PULSE_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .addr(addr),
    .wdata(wdata), .pulse_tick(pulse_tick), .cell_busy(cell_busy), .rst_cmd(rst_cmd),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic srd(input logic [3:0] a, input logic [7:0] base, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, base | {1'b0, exp_tgl, 6'b0});
    exp_tgl = ~exp_tgl;
  endtask

  task automatic go(input logic er, input logic [3:0] a, input logic [7:0] d, input logic accepted);
    @(negedge clk); start = 1; op_erase = er; addr = a; wdata = d;
    @(negedge clk); start = 0;
    if (accepted) exp_tgl = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_tick = 1;
      @(negedge clk); pulse_tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd3, d); chk("R1 reset word", d, 8'hFF);
    rd(4'd15, d); chk("R1 reset word top", d, 8'hFF);
  endtask

  task automatic t_program_ok();
    logic [7:0] d, d2;
    cell_busy = 0;
    go(0, 4'd3, 8'h35, 1);
    srd(4'd3, 8'h80, "R3 poll complement at latched addr");
    srd(4'd5, 8'h00, "R3 poll zero at other addr");
    srd(4'd3, 8'h80, "R5 toggle back to 0 / R6 bit5 0");
    pulses(1);
    rd(4'd3, d); chk("R2 program stored", d, 8'h35);
    rd(4'd3, d2); chk("R2 no toggle after done", d2, 8'h35);
    go(0, 4'd3, 8'h14, 1);
    pulses(1);
    rd(4'd3, d); chk("R2 AND-only update", d, 8'h14);
  endtask

  task automatic t_limit_boundary();
    logic [7:0] d;
    cell_busy = 1;
    go(0, 4'd7, 8'h8F, 1);
    pulses(LIMIT);
    srd(4'd7, 8'h00, "R7 still running at limit, R4 bit3 0 on program");
    cell_busy = 0;
    pulses(1);
    rd(4'd7, d); chk("R7 completion at boundary", d, 8'h8F);
  endtask

  task automatic t_bad_program();
    logic [7:0] d;
    cell_busy = 0;
    go(0, 4'd3, 8'h16, 1);
    pulses(LIMIT);
    srd(4'd3, 8'h80, "R8 running before limit exceeded, R6");
    pulses(1);
    srd(4'd3, 8'hA0, "R8 bit5 set after limit exceeded");
    srd(4'd3, 8'hA0, "R9 fail latched, R5 toggles while failed");
    go(0, 4'd9, 8'h00, 0);
    srd(4'd9, 8'h20, "R10 start ignored while failed");
    @(negedge clk); rst_cmd = 1;
    @(negedge clk); rst_cmd = 0;
    rd(4'd9, d); chk("R9 array read after reset cmd / R10", d, 8'hFF);
    rd(4'd3, d); chk("R8 word unchanged by failed program", d, 8'h14);
  endtask

  task automatic t_erase();
    logic [7:0] d;
    cell_busy = 1;
    go(1, 4'd0, 8'h00, 1);
    srd(4'd3, 8'h08, "R4 erase status bit3 1 bit7 0");
    go(0, 4'd0, 8'h00, 0);
    srd(4'd0, 8'h08, "R10 start ignored while busy");
    @(negedge clk); rst_cmd = 1;
    @(negedge clk); rst_cmd = 0;
    srd(4'd0, 8'h08, "R10 reset cmd ignored while running");
    cell_busy = 0;
    pulses(1);
    rd(4'd3, d); chk("R11 erase fills word 3", d, 8'hFF);
    rd(4'd7, d); chk("R11 erase fills word 7", d, 8'hFF);
    rd(4'd0, d); chk("R11 ignored program left word 0", d, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program_ok();
    t_limit_boundary();
    t_bad_program();
    t_erase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule